// File: doc/BRIEF.md
# Planar Display Memory Write Datapath

This block sits between a byte-wide CPU port and four bit-planes of display memory. Each CPU byte address maps to one byte in every plane. A read of display memory does two things. It returns a byte to the CPU, and it captures all four plane bytes into a 32-bit latch. A later write builds four new plane bytes from several sources:
- the CPU byte, rotated right,
- a 4-bit fill colour, either per plane or for all planes,
- a logic function applied against the latch,
- a per-bit mask that keeps latched bits unchanged.

This lets software copy, fill and blend eight pixels across four planes with one bus access.

Control registers are reached through an index/data pair. A write with `reg_sel` low sets the index. A write with `reg_sel` high writes the indexed register. `reg_rdata` always shows either the index or the indexed register, depending on `reg_sel`.

The register map uses a 4-bit index:

| Index | Contents |
|-------|----------|
| 0 | Fill colour |
| 1 | Per-plane fill select |
| 2 | Compare colour |
| 3 | Rotate count (bits 2:0) and function (bits 4:3) |
| 4 | Read plane (bits 1:0) |
| 5 | Write mode (bits 1:0) and read mode (bit 3) |
| 7 | Compare-enable planes |
| 8 | Bit mask |

All other indices read 0 and ignore writes.

The memory arrays are outside the block. The block presents four plane write strobes and 32 bits of write data. Plane `p` is always bits 8p+7:8p. The block takes the four addressed plane bytes back on `plane_rd_data`.

Top module: `planar_gfx_datapath`

## Requirements
- R1: After reset every register reads 0, except the bit mask (index 8), which reads 0xFF. The index register also reads 0.
- R2: Index and data access behaves as follows:
  - A write with `reg_sel`=0 stores the low 4 bits of the data as the index.
  - A write with `reg_sel`=1 updates the indexed register.
  - `reg_rdata` shows the index when `reg_sel`=0 and the indexed register when `reg_sel`=1.
  - Unused indices read 0 and writes to them change nothing.
- R3: A cycle with `cpu_rd` high loads all 32 bits of `plane_rd_data` into the latch at the clock edge. The latch holds its value in every other cycle.
- R4: Read mode 0 (mode bit 3 = 0) returns the byte of the plane chosen by index 4 bits 1:0, in the same cycle.
- R5: Read mode 1 (mode bit 3 = 1) returns a byte whose bit b is 1 when every plane p with index 7 bit p = 1 has bit b equal to index 2 bit p. With no plane enabled, it returns 0xFF.
- R6: Write mode 0 (mode bits 1:0 = 0) rotates the CPU byte right by index 3 bits 2:0 and uses it as the data for every plane.
- R7: In write modes 0, plane p takes 0x00 or 0xFF from fill colour bit p instead of the rotated byte when index 1 bit p = 1.
- R8: Index 3 bits 4:3 choose the function of data against the latch byte: 0 pass, 1 AND, 2 OR, 3 XOR.
- R9: Where a bit of the mask (index 8) is 0, the written bit equals the latched bit, in every write mode.
- R10: Write mode 1 writes the latch unchanged to all planes. It ignores the CPU byte and the mask.
- R11: Write mode 2 fills plane p with CPU bit p repeated eight times. The function and the mask then apply.
- R12: Write mode 3 uses fill colour bit p, repeated eight times, as the data for plane p. The function applies. The mask is the rotated CPU byte ANDed with index 8.
- R13: `plane_wr_en` equals `plane_wr_en_in` in a cycle with `cpu_wr` high, and is 0 otherwise. Disabled planes keep their memory contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the index, 1 selects the indexed register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Index or indexed register value |
| cpu_rd | input | 1 | Display memory read; loads the latch |
| cpu_wr | input | 1 | Display memory write |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Byte returned for a memory read |
| plane_rd_data | input | 32 | Addressed byte of each plane, plane p in bits 8p+7:8p |
| plane_wr_en_in | input | 4 | Planes allowed to be written |
| plane_wr_en | output | 4 | Per-plane write strobe to memory |
| plane_wr_data | output | 32 | Per-plane write data |

## Verification
`reg_rdata`, `cpu_rdata`, `plane_wr_en` and `plane_wr_data` are combinational outputs. They are valid in the same cycle as the stimulus that produces them. A register write takes effect at the clock edge that ends its cycle. A read loads the latch at the clock edge that ends the read cycle, so the latch first affects write data in the following cycle.

The bench changes inputs just after a rising edge and samples outputs at the falling edge. Each write vector therefore follows this order:
1. One cycle to load the latch.
2. One cycle to drive the write.
3. Check the write data at the middle of that write cycle.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
  localparam int NPLANES = 4;
  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 4;
  localparam int ROT_W   = $clog2(BYTE_W);
  localparam int WORD_W  = NPLANES * BYTE_W;

  localparam logic [IDX_W-1:0] IX_FILL   = 4'd0;
  localparam logic [IDX_W-1:0] IX_FILLEN = 4'd1;
  localparam logic [IDX_W-1:0] IX_CCOL   = 4'd2;
  localparam logic [IDX_W-1:0] IX_ROTFN  = 4'd3;
  localparam logic [IDX_W-1:0] IX_RPLANE = 4'd4;
  localparam logic [IDX_W-1:0] IX_MODE   = 4'd5;
  localparam logic [IDX_W-1:0] IX_CEN    = 4'd7;
  localparam logic [IDX_W-1:0] IX_BMASK  = 4'd8;

  typedef enum logic [1:0] {
    WM_DIRECT = 2'd0,
    WM_LATCH  = 2'd1,
    WM_EXPAND = 2'd2,
    WM_MASKED = 2'd3
  } wmode_e;

  typedef enum logic [1:0] {
    FN_PASS = 2'd0,
    FN_AND  = 2'd1,
    FN_OR   = 2'd2,
    FN_XOR  = 2'd3
  } func_e;

  typedef struct packed {
    logic [NPLANES-1:0] fill;
    logic [NPLANES-1:0] fill_en;
    logic [NPLANES-1:0] ccol;
    logic [NPLANES-1:0] cen;
    logic [ROT_W-1:0]   rot;
    func_e              func;
    logic [1:0]         rplane;
    wmode_e             wmode;
    logic               rmode;
    logic [BYTE_W-1:0]  bmask;
  } gfx_cfg_t;

  function automatic logic [BYTE_W-1:0] rot_right(input logic [BYTE_W-1:0] d,
                                                  input logic [ROT_W-1:0] n);
    logic [2*BYTE_W-1:0] dbl;
    dbl = {d, d} >> n;
    return dbl[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] apply_func(input func_e f,
                                                   input logic [BYTE_W-1:0] d,
                                                   input logic [BYTE_W-1:0] l);
    logic [BYTE_W-1:0] r;
    case (f)
      FN_AND:  r = d & l;
      FN_OR:   r = d | l;
      FN_XOR:  r = d ^ l;
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] merge_bits(input logic [BYTE_W-1:0] newv,
                                                   input logic [BYTE_W-1:0] oldv,
                                                   input logic [BYTE_W-1:0] m);
    return (newv & m) | (oldv & ~m);
  endfunction
endpackage

// File: rtl/gfx_regfile.sv
module gfx_regfile
  import gfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output gfx_cfg_t          cfg
);
  logic [IDX_W-1:0] idx_q;
  logic             data_wr;

  assign data_wr = reg_wr & reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q       <= '0;
      cfg.fill    <= '0;
      cfg.fill_en <= '0;
      cfg.ccol    <= '0;
      cfg.cen     <= '0;
      cfg.rot     <= '0;
      cfg.func    <= FN_PASS;
      cfg.rplane  <= '0;
      cfg.wmode   <= WM_DIRECT;
      cfg.rmode   <= 1'b0;
      cfg.bmask   <= '1;
    end else if (reg_wr && !reg_sel) begin
      idx_q <= reg_wdata[IDX_W-1:0];
    end else if (data_wr) begin
      case (idx_q)
        IX_FILL:   cfg.fill    <= reg_wdata[NPLANES-1:0];
        IX_FILLEN: cfg.fill_en <= reg_wdata[NPLANES-1:0];
        IX_CCOL:   cfg.ccol    <= reg_wdata[NPLANES-1:0];
        IX_ROTFN: begin
          cfg.rot  <= reg_wdata[ROT_W-1:0];
          cfg.func <= func_e'(reg_wdata[ROT_W+1:ROT_W]);
        end
        IX_RPLANE: cfg.rplane  <= reg_wdata[1:0];
        IX_MODE: begin
          cfg.wmode <= wmode_e'(reg_wdata[1:0]);
          cfg.rmode <= reg_wdata[3];
        end
        IX_CEN:    cfg.cen     <= reg_wdata[NPLANES-1:0];
        IX_BMASK:  cfg.bmask   <= reg_wdata;
        default: ;
      endcase
    end
  end

  logic [BYTE_W-1:0] sel_val;
  always_comb begin
    sel_val = '0;
    case (idx_q)
      IX_FILL:   sel_val[NPLANES-1:0] = cfg.fill;
      IX_FILLEN: sel_val[NPLANES-1:0] = cfg.fill_en;
      IX_CCOL:   sel_val[NPLANES-1:0] = cfg.ccol;
      IX_ROTFN:  sel_val[ROT_W+1:0]   = {cfg.func, cfg.rot};
      IX_RPLANE: sel_val[1:0]         = cfg.rplane;
      IX_MODE: begin
        sel_val[1:0] = cfg.wmode;
        sel_val[3]   = cfg.rmode;
      end
      IX_CEN:    sel_val[NPLANES-1:0] = cfg.cen;
      IX_BMASK:  sel_val              = cfg.bmask;
      default:   sel_val              = '0;
    endcase
  end

  assign reg_rdata = reg_sel ? sel_val : {{(BYTE_W-IDX_W){1'b0}}, idx_q};

  // R2
  bmask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_q == IX_BMASK) |=> (cfg.bmask == $past(reg_wdata)));

  // R2
  idx_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel) |=> (idx_q == $past(reg_wdata[IDX_W-1:0])));
endmodule

// File: rtl/gfx_read_unit.sv
module gfx_read_unit
  import gfx_pkg::*;
(
  input  logic [WORD_W-1:0] plane_bytes,
  input  gfx_cfg_t          cfg,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] cmp_byte
);
  logic [BYTE_W-1:0] sel_byte;

  always_comb begin
    sel_byte = plane_bytes[cfg.rplane*BYTE_W +: BYTE_W];
  end

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    logic [NPLANES-1:0] miss;
    for (genvar p = 0; p < NPLANES; p++) begin : g_pl
      assign miss[p] = cfg.cen[p] & (plane_bytes[p*BYTE_W+b] ^ cfg.ccol[p]);
    end
    assign cmp_byte[b] = ~|miss;
  end

  assign rd_byte = cfg.rmode ? cmp_byte : sel_byte;
endmodule

// File: rtl/gfx_write_unit.sv
module gfx_write_unit
  import gfx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_wr,
  input  logic [BYTE_W-1:0]   cpu_wdata,
  input  logic [WORD_W-1:0]   latch,
  input  logic [NPLANES-1:0]  wr_en_in,
  input  gfx_cfg_t            cfg,
  output logic [NPLANES-1:0]  wr_en,
  output logic [WORD_W-1:0]   wr_data
);
  logic [BYTE_W-1:0] rotated;
  logic [BYTE_W-1:0] eff_mask;

  assign rotated  = rot_right(cpu_wdata, cfg.rot);
  assign eff_mask = (cfg.wmode == WM_MASKED) ? (rotated & cfg.bmask) : cfg.bmask;

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    logic [BYTE_W-1:0] lat_b;
    logic [BYTE_W-1:0] src_b;
    logic [BYTE_W-1:0] fn_b;

    assign lat_b = latch[p*BYTE_W +: BYTE_W];

    always_comb begin
      case (cfg.wmode)
        WM_EXPAND: src_b = {BYTE_W{cpu_wdata[p]}};
        WM_MASKED: src_b = {BYTE_W{cfg.fill[p]}};
        default:   src_b = cfg.fill_en[p] ? {BYTE_W{cfg.fill[p]}} : rotated;
      endcase
    end

    assign fn_b = apply_func(cfg.func, src_b, lat_b);

    assign wr_data[p*BYTE_W +: BYTE_W] =
      (cfg.wmode == WM_LATCH) ? lat_b : merge_bits(fn_b, lat_b, eff_mask);
  end

  assign wr_en = cpu_wr ? wr_en_in : '0;

  // R10
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cfg.wmode == WM_LATCH) |-> (wr_data == latch));

  // R9
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> (((wr_data ^ latch) & ~{NPLANES{cfg.bmask}}) == '0));

  // R13
  plane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en & ~wr_en_in) == '0) && (!cpu_wr -> (wr_en == '0)));
endmodule

// File: rtl/planar_gfx_datapath.sv
module planar_gfx_datapath
  import gfx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  input  logic [31:0]        plane_rd_data,
  input  logic [3:0]         plane_wr_en_in,
  output logic [3:0]         plane_wr_en,
  output logic [31:0]        plane_wr_data
);
  gfx_cfg_t          cfg;
  logic [WORD_W-1:0] latch_q;
  logic [BYTE_W-1:0] cmp_byte;
  logic              latch_load;

  assign latch_load = cpu_rd;

  gfx_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg       (cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          latch_q <= '0;
    else if (latch_load) latch_q <= plane_rd_data;
  end

  gfx_read_unit u_rd (
    .plane_bytes (plane_rd_data),
    .cfg         (cfg),
    .rd_byte     (cpu_rdata),
    .cmp_byte    (cmp_byte)
  );

  gfx_write_unit u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .latch     (latch_q),
    .wr_en_in  (plane_wr_en_in),
    .cfg       (cfg),
    .wr_en     (plane_wr_en),
    .wr_data   (plane_wr_data)
  );

  // R3
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_load |=> (latch_q == $past(plane_rd_data)));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_load |=> $stable(latch_q));

  // R5
  cmp_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.cen == '0) |-> (cmp_byte == '1));
endmodule

// File: tb/planar_gfx_datapath_tb.sv
module planar_gfx_datapath_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata;
  logic [31:0] plane_rd_data;
  logic [3:0]  plane_wr_en_in = 4'hF, plane_wr_en;
  logic [31:0] plane_wr_data;

  logic [31:0] ram [16];
  logic [3:0]  addr = '0;
  logic        pre_en = 1'b0;
  logic [3:0]  pre_addr = '0;
  logic [31:0] pre_val = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  planar_gfx_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .plane_rd_data(plane_rd_data), .plane_wr_en_in(plane_wr_en_in),
    .plane_wr_en(plane_wr_en), .plane_wr_data(plane_wr_data)
  );

  assign plane_rd_data = ram[addr];

  always @(posedge clk) begin
    if (pre_en) ram[pre_addr] <= pre_val;
    else
      for (int p = 0; p < 4; p++)
        if (plane_wr_en[p]) ram[addr][p*8 +: 8] <= plane_wr_data[p*8 +: 8];
  end

  typedef struct packed {
    logic [1:0]  wm;
    logic [1:0]  fn;
    logic [2:0]  rot;
    logic [3:0]  fill;
    logic [3:0]  fen;
    logic [7:0]  bm;
    logic [31:0] lat;
    logic [7:0]  cpu;
    logic [31:0] exp_d;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 32'h00000000, 8'hA5, 32'hA5A5A5A5}, // R6
    '{2'd0, 2'd0, 3'd1, 4'h0, 4'h0, 8'hFF, 32'h00000000, 8'h03, 32'h81818181}, // R6
    '{2'd0, 2'd0, 3'd3, 4'h0, 4'h0, 8'hFF, 32'h00000000, 8'h01, 32'h20202020}, // R6
    '{2'd0, 2'd0, 3'd0, 4'h1, 4'h5, 8'hFF, 32'h00000000, 8'h3C, 32'h3C003CFF}, // R7
    '{2'd0, 2'd1, 3'd0, 4'h0, 4'h0, 8'hFF, 32'h12345678, 8'hF0, 32'h10305070}, // R8
    '{2'd0, 2'd2, 3'd0, 4'h0, 4'h0, 8'hFF, 32'h12345678, 8'h0F, 32'h1F3F5F7F}, // R8
    '{2'd0, 2'd3, 3'd0, 4'h0, 4'h0, 8'hFF, 32'h12345678, 8'hFF, 32'hEDCBA987}, // R8
    '{2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'h0F, 32'hAAAAAAAA, 8'h55, 32'hA5A5A5A5}, // R9
    '{2'd1, 2'd0, 3'd0, 4'h0, 4'h0, 8'h00, 32'h12345678, 8'h00, 32'h12345678}, // R10 R3
    '{2'd2, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 32'h00000000, 8'h05, 32'h00FF00FF}, // R11
    '{2'd2, 2'd0, 3'd0, 4'h0, 4'h0, 8'hF0, 32'h0F0F0F0F, 8'h0A, 32'hFF0FFF0F}, // R11
    '{2'd3, 2'd0, 3'd0, 4'h3, 4'h0, 8'hF0, 32'h00000000, 8'h3C, 32'h00003030}, // R12
    '{2'd3, 2'd0, 3'd2, 4'hF, 4'h0, 8'hFF, 32'h00000000, 8'h0F, 32'hC3C3C3C3}, // R12
    '{2'd0, 2'd3, 3'd4, 4'h0, 4'h0, 8'hFF, 32'hFFFFFFFF, 8'h12, 32'hDEDEDEDE}  // R6 R8
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic reg_write(input logic [3:0] idx, input logic [7:0] val);
    reg_wr = 1; reg_sel = 0; reg_wdata = {4'h0, idx}; step();
    reg_sel = 1; reg_wdata = val; step();
    reg_wr = 0;
  endtask

  task automatic reg_peek(input logic [3:0] idx, output logic [7:0] val);
    reg_wr = 1; reg_sel = 0; reg_wdata = {4'h0, idx}; step();
    reg_wr = 0; reg_sel = 1;
    @(negedge clk); val = reg_rdata;
    step();
  endtask

  task automatic preload(input logic [3:0] a, input logic [31:0] v);
    pre_en = 1; pre_addr = a; pre_val = v; step();
    pre_en = 0;
  endtask

  task automatic mem_read(input logic [3:0] a, output logic [7:0] b);
    addr = a; cpu_rd = 1;
    @(negedge clk); b = cpu_rdata;
    step(); cpu_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 16; i++) ram[i] = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1; step();

    // R1 reset values
    @(negedge clk); chk("R1 index", {24'h0, reg_rdata}, 32'h0);
    step();
    reg_peek(4'd8, v); chk("R1 bitmask", {24'h0, v}, 32'hFF);
    reg_peek(4'd0, v); chk("R1 fill", {24'h0, v}, 32'h0);
    reg_peek(4'd5, v); chk("R1 mode", {24'h0, v}, 32'h0);

    // R2 register access
    reg_write(4'd3, 8'h1B);
    reg_peek(4'd3, v); chk("R2 rotfn readback", {24'h0, v}, 32'h1B);
    reg_sel = 0; @(negedge clk); chk("R2 index readback", {24'h0, reg_rdata}, 32'h3); step();
    reg_write(4'd6, 8'hFF);
    reg_peek(4'd6, v); chk("R2 unused index", {24'h0, v}, 32'h0);
    reg_write(4'd3, 8'h00);

    // vector table: modes, rotate, fill, function, mask
    for (int i = 0; i < NV; i++) begin
      reg_write(4'd5, {6'h0, VEC[i].wm});
      reg_write(4'd3, {3'h0, VEC[i].fn, VEC[i].rot});
      reg_write(4'd0, {4'h0, VEC[i].fill});
      reg_write(4'd1, {4'h0, VEC[i].fen});
      reg_write(4'd8, VEC[i].bm);
      preload(4'd0, VEC[i].lat);
      mem_read(4'd0, v);
      addr = 4'd1; cpu_wr = 1; cpu_wdata = VEC[i].cpu;
      @(negedge clk);
      chk($sformatf("vec%0d R6-R12 data", i), plane_wr_data, VEC[i].exp_d);
      chk("R13 enable all", {28'h0, plane_wr_en}, 32'hF);
      step(); cpu_wr = 0;
    end

    // R3 latch unaffected by write: copy latch again in mode 1
    reg_write(4'd5, 8'h01);
    addr = 4'd2; cpu_wr = 1; cpu_wdata = 8'h00; @(negedge clk);
    chk("R3 latch kept", plane_wr_data, 32'hFFFFFFFF); step(); cpu_wr = 0;

    // R4 read mode 0 plane select
    reg_write(4'd5, 8'h00);
    preload(4'd2, 32'h44332211);
    reg_write(4'd4, 8'h02);
    mem_read(4'd2, v); chk("R4 plane2", {24'h0, v}, 32'h33);
    reg_write(4'd4, 8'h00);
    mem_read(4'd2, v); chk("R4 plane0", {24'h0, v}, 32'h11);

    // R5 read mode 1 compare
    preload(4'd3, 32'h00AACCF0);
    reg_write(4'd5, 8'h08);
    reg_write(4'd2, 8'h03);
    reg_write(4'd7, 8'h03);
    mem_read(4'd3, v); chk("R5 two planes", {24'h0, v}, 32'hC0);
    reg_write(4'd7, 8'h0F);
    mem_read(4'd3, v); chk("R5 four planes", {24'h0, v}, 32'h40);
    reg_write(4'd7, 8'h00);
    mem_read(4'd3, v); chk("R5 none enabled", {24'h0, v}, 32'hFF);

    // R13 plane write gating
    reg_write(4'd5, 8'h00);
    reg_write(4'd3, 8'h00);
    reg_write(4'd8, 8'hFF);
    preload(4'd4, 32'h0);
    addr = 4'd4; @(negedge clk);
    chk("R13 idle no strobe", {28'h0, plane_wr_en}, 32'h0); step();
    plane_wr_en_in = 4'h5; cpu_wr = 1; cpu_wdata = 8'hFF; @(negedge clk);
    chk("R13 gated strobe", {28'h0, plane_wr_en}, 32'h5);
    step(); cpu_wr = 0; plane_wr_en_in = 4'hF;
    reg_write(4'd4, 8'h01);
    mem_read(4'd4, v); chk("R13 plane1 kept", {24'h0, v}, 32'h00);
    reg_write(4'd4, 8'h00);
    mem_read(4'd4, v); chk("R13 plane0 written", {24'h0, v}, 32'hFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule